// File: doc/BRIEF.md
# SPI FIFO Status Flag and Receive Timeout Unit

This unit produces the status flags of an SPI controller whose transmit and receive paths each have a FIFO. It does not hold the FIFOs or the shift engine. It watches their fill levels, a busy signal from the transmit shift register and two strobes: one for a word arriving in the receive FIFO and one for software reading the data register. From these it derives four flags:

- **transmit-buffer-empty**: the transmit side can take more data.
- **transmission-empty**: nothing is left to send.
- **receive-not-empty**: received data is waiting.
- **receive timeout**: the receive FIFO has held data for too long with no traffic.

In FIFO mode the two buffer flags compare the levels against thresholds that software programs. In single-buffer mode the levels are 0 or 1 and the flags mean plain empty and plain occupied.

The timeout logic counts enable ticks from a prescaled clock while the receive FIFO holds data. Any receive or read restarts the count. When the count reaches the programmed compare value, the sticky timeout flag is raised. Software clears the flag by writing a 1 to it. All four flags are registered and follow their inputs one clock later. Reset is synchronous and active high.

Top module: `spi_fifo_status`

## Requirements
- R1: While reset is high and on the first cycle after it, transmit-buffer-empty and transmission-empty read 1, and receive-not-empty and timeout read 0.
- R2: With fifo_mode=1, tx_buf_empty equals (tx_level <= tx_thresh) as sampled on the previous clock edge.
- R3: With fifo_mode=0, tx_buf_empty equals (tx_level == 0) as sampled on the previous clock edge.
- R4: In either mode, tx_all_empty is 1 exactly when, at the previous edge, tx_level was 0 and shift_busy was 0.
- R5: With fifo_mode=1, rx_not_empty equals (rx_level >= rx_thresh) as sampled on the previous edge.
- R6: With fifo_mode=0, rx_not_empty equals (rx_level != 0) as sampled on the previous edge.
- R7: The idle counter advances by one on each edge where all of the following hold: fifo_mode=1, rx_level is nonzero, toc_value is nonzero, tick=1, rx_push=0 and dr_read=0. On the edge where the counter reaches toc_value, timeout_flag becomes 1.
- R8: An edge with rx_push=1 or dr_read=1 returns the counter to 0. This takes priority over a tick.
- R9: The counter is returned to 0 when any of these holds: the receive FIFO is empty, fifo_mode=0, or toc_value=0. A pending timeout_flag is kept in all of these cases.
- R10: An edge with flag_wr=1 and flag_wdata=1 clears timeout_flag. A write with flag_wdata=0 leaves it unchanged. If a set and a clear fall on the same edge, the set wins.
- R11: The counter saturates at toc_value and does not wrap. After a clear, timeout_flag stays 0 until the counter has been restarted and reaches toc_value again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_mode | input | 1 | 1 = FIFO mode, 0 = single-buffer mode |
| tx_level | input | LVL_W | Words held in the transmit FIFO |
| tx_thresh | input | LVL_W | Transmit threshold level |
| shift_busy | input | 1 | Transmit shift register holds data |
| rx_level | input | LVL_W | Words held in the receive FIFO |
| rx_thresh | input | LVL_W | Receive threshold level |
| tick | input | 1 | Prescaled timeout count enable |
| toc_value | input | TOC_W | Timeout compare value, 0 disables |
| rx_push | input | 1 | A word was received into the FIFO |
| dr_read | input | 1 | Software read of the data register |
| flag_wr | input | 1 | Write strobe to the timeout flag |
| flag_wdata | input | 1 | Write data, 1 clears the flag |
| tx_buf_empty | output | 1 | Transmit buffer can accept data |
| tx_all_empty | output | 1 | Transmit buffer and shifter both empty |
| rx_not_empty | output | 1 | Receive data available |
| timeout_flag | output | 1 | Receive idle timeout pending |

## Verification
The hardest condition to reach from the ports is a timeout that sets on the same edge as a write-1 clear. A second hard case is a clear that arrives after the counter has saturated, where the flag must then stay low. Random stimulus rarely holds the receive FIFO non-empty with no receive or read for enough ticks to get there. The stimulus therefore has directed phases that:
- hold a small compare value with steady ticks and no traffic;
- time the clear write to the tick that completes the count;
- clear during saturation, then restart the count with a read.

A random phase follows that biases the compare value low and the strobes rare.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;

    typedef enum logic {
        BUF_SINGLE = 1'b0,
        BUF_FIFO   = 1'b1
    } buf_mode_e;

    typedef struct packed {
        logic txbe;
        logic txe;
        logic rxne;
        logic tmo;
    } stat_flags_t;

    localparam stat_flags_t FLAGS_RESET = '{txbe: 1'b1, txe: 1'b1, rxne: 1'b0, tmo: 1'b0};

    function automatic buf_mode_e to_mode(input logic m);
        return m ? BUF_FIFO : BUF_SINGLE;
    endfunction

endpackage

// File: rtl/spi_stat_txflags.sv
module spi_stat_txflags
    import spi_stat_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  buf_mode_e        mode,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] thresh,
    input  logic             shift_busy,
    output logic             buf_empty,
    output logic             all_empty
);
    logic lvl_zero;
    logic txbe_d;

    assign lvl_zero = (level == '0);

    always_comb begin
        case (mode)
            BUF_FIFO:   txbe_d = (level <= thresh);
            default:    txbe_d = lvl_zero;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_empty <= FLAGS_RESET.txbe;
            all_empty <= FLAGS_RESET.txe;
        end else begin
            buf_empty <= txbe_d;
            all_empty <= lvl_zero && !shift_busy;
        end
    end
endmodule

// File: rtl/spi_stat_rxflag.sv
module spi_stat_rxflag
    import spi_stat_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  buf_mode_e        mode,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] thresh,
    output logic             not_empty
);
    logic rxne_d;

    always_comb begin
        case (mode)
            BUF_FIFO:   rxne_d = (level >= thresh);
            default:    rxne_d = (level != '0);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) not_empty <= FLAGS_RESET.rxne;
        else     not_empty <= rxne_d;
    end
endmodule

// File: rtl/spi_stat_timeout.sv
module spi_stat_timeout
    import spi_stat_pkg::*;
#(
    parameter int LVL_W = 4,
    parameter int TOC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  buf_mode_e        mode,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [TOC_W-1:0] toc_value,
    input  logic             tick,
    input  logic             rx_push,
    input  logic             dr_read,
    input  logic             clr_wr,
    input  logic             clr_bit,
    output logic             flag,
    output logic [TOC_W-1:0] count
);
    localparam int EXT_W = TOC_W + 1;

    logic             armed;
    logic             restart;
    logic             below;
    logic             advance;
    logic [EXT_W-1:0] count_inc;
    logic             hit;

    assign armed     = (mode == BUF_FIFO) && (rx_level != '0) && (toc_value != '0);
    assign restart   = !armed || rx_push || dr_read;
    assign below     = (count < toc_value);
    assign advance   = tick && below;
    assign count_inc = {1'b0, count} + EXT_W'(1);
    assign hit       = !restart && advance && (count_inc == {1'b0, toc_value});

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (restart) begin
            count <= '0;
        end else if (advance) begin
            count <= count_inc[TOC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= FLAGS_RESET.tmo;
        end else if (hit) begin
            flag <= 1'b1;
        end else if (clr_wr && clr_bit) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_fifo_status.sv
module spi_fifo_status
    import spi_stat_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TOC_W = 8,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_mode,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] tx_thresh,
    input  logic             shift_busy,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] rx_thresh,
    input  logic             tick,
    input  logic [TOC_W-1:0] toc_value,
    input  logic             rx_push,
    input  logic             dr_read,
    input  logic             flag_wr,
    input  logic             flag_wdata,
    output logic             tx_buf_empty,
    output logic             tx_all_empty,
    output logic             rx_not_empty,
    output logic             timeout_flag
);
    buf_mode_e        mode;
    stat_flags_t      flags;
    logic [TOC_W-1:0] idle_count;

    assign mode = to_mode(fifo_mode);

    spi_stat_txflags #(.LVL_W(LVL_W)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .level      (tx_level),
        .thresh     (tx_thresh),
        .shift_busy (shift_busy),
        .buf_empty  (flags.txbe),
        .all_empty  (flags.txe)
    );

    spi_stat_rxflag #(.LVL_W(LVL_W)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .level     (rx_level),
        .thresh    (rx_thresh),
        .not_empty (flags.rxne)
    );

    spi_stat_timeout #(.LVL_W(LVL_W), .TOC_W(TOC_W)) u_tmo (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .rx_level  (rx_level),
        .toc_value (toc_value),
        .tick      (tick),
        .rx_push   (rx_push),
        .dr_read   (dr_read),
        .clr_wr    (flag_wr),
        .clr_bit   (flag_wdata),
        .flag      (flags.tmo),
        .count     (idle_count)
    );

    assign tx_buf_empty = flags.txbe;
    assign tx_all_empty = flags.txe;
    assign rx_not_empty = flags.rxne;
    assign timeout_flag = flags.tmo;
endmodule

// File: rtl/spi_fifo_status_chk.sv
module spi_fifo_status_chk #(
    parameter int LVL_W = 4,
    parameter int TOC_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             fifo_mode,
    input logic [LVL_W-1:0] tx_level,
    input logic [LVL_W-1:0] tx_thresh,
    input logic             shift_busy,
    input logic [LVL_W-1:0] rx_level,
    input logic [LVL_W-1:0] rx_thresh,
    input logic             tick,
    input logic [TOC_W-1:0] toc_value,
    input logic             rx_push,
    input logic             dr_read,
    input logic             flag_wr,
    input logic             flag_wdata,
    input logic             tx_buf_empty,
    input logic             tx_all_empty,
    input logic             rx_not_empty,
    input logic             timeout_flag,
    input logic [TOC_W-1:0] idle_count
);
    p_txbe_fifo_r2: assert property (@(posedge clk) disable iff (rst)
        fifo_mode |=> (tx_buf_empty == ($past(tx_level) <= $past(tx_thresh))));

    p_txbe_single_r3: assert property (@(posedge clk) disable iff (rst)
        !fifo_mode |=> (tx_buf_empty == ($past(tx_level) == '0)));

    p_txe_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (tx_all_empty == (($past(tx_level) == '0) && !$past(shift_busy))));

    p_rxne_fifo_r5: assert property (@(posedge clk) disable iff (rst)
        fifo_mode |=> (rx_not_empty == ($past(rx_level) >= $past(rx_thresh))));

    p_rxne_single_r6: assert property (@(posedge clk) disable iff (rst)
        !fifo_mode |=> (rx_not_empty == ($past(rx_level) != '0)));

    p_set_in_fifo_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_flag) |-> ($past(fifo_mode) && $past(tick) && (idle_count == $past(toc_value))));

    p_restart_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_push || dr_read) |=> (idle_count == '0));

    p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (!fifo_mode || rx_level == '0 || toc_value == '0) |=> (idle_count == '0));

    p_hold_on_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (timeout_flag && !(flag_wr && flag_wdata)) |=> timeout_flag);

    p_write0_r10: assert property (@(posedge clk) disable iff (rst)
        (timeout_flag && flag_wr && !flag_wdata) |=> timeout_flag);

    p_no_wrap_r11: assert property (@(posedge clk) disable iff (rst)
        ((idle_count == toc_value) && $stable(toc_value) && !rx_push && !dr_read && fifo_mode
          && rx_level != '0 && toc_value != '0) |=> (idle_count == $past(toc_value)));
endmodule

bind spi_fifo_status spi_fifo_status_chk #(.LVL_W(LVL_W), .TOC_W(TOC_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .fifo_mode    (fifo_mode),
    .tx_level     (tx_level),
    .tx_thresh    (tx_thresh),
    .shift_busy   (shift_busy),
    .rx_level     (rx_level),
    .rx_thresh    (rx_thresh),
    .tick         (tick),
    .toc_value    (toc_value),
    .rx_push      (rx_push),
    .dr_read      (dr_read),
    .flag_wr      (flag_wr),
    .flag_wdata   (flag_wdata),
    .tx_buf_empty (tx_buf_empty),
    .tx_all_empty (tx_all_empty),
    .rx_not_empty (rx_not_empty),
    .timeout_flag (timeout_flag),
    .idle_count   (idle_count)
);

// File: tb/test_spi_fifo_status.sv
`timescale 1ns/1ps
module test_spi_fifo_status;
    localparam int DEPTH = 8;
    localparam int TOC_W = 8;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst;
    logic             fifo_mode;
    logic [LVL_W-1:0] tx_level, tx_thresh, rx_level, rx_thresh;
    logic             shift_busy, tick, rx_push, dr_read, flag_wr, flag_wdata;
    logic [TOC_W-1:0] toc_value;
    logic             tx_buf_empty, tx_all_empty, rx_not_empty, timeout_flag;

    int n_checks = 0;
    int n_fail   = 0;
    int n_cycles = 0;
    bit done     = 1'b0;

    // expected state, computed from the requirements
    logic e_txbe, e_txe, e_rxne, e_tmo;
    int   m_cnt;

    always #5 clk = ~clk;

    spi_fifo_status #(.DEPTH(DEPTH), .TOC_W(TOC_W)) i_spi_fifo_status (
        .clk(clk), .rst(rst), .fifo_mode(fifo_mode),
        .tx_level(tx_level), .tx_thresh(tx_thresh), .shift_busy(shift_busy),
        .rx_level(rx_level), .rx_thresh(rx_thresh), .tick(tick),
        .toc_value(toc_value), .rx_push(rx_push), .dr_read(dr_read),
        .flag_wr(flag_wr), .flag_wdata(flag_wdata),
        .tx_buf_empty(tx_buf_empty), .tx_all_empty(tx_all_empty),
        .rx_not_empty(rx_not_empty), .timeout_flag(timeout_flag)
    );

    function automatic logic exp_txbe(input logic fm, input int lvl, input int thr);
        return fm ? (lvl <= thr) : (lvl == 0);          // R2, R3
    endfunction

    function automatic logic exp_rxne(input logic fm, input int lvl, input int thr);
        return fm ? (lvl >= thr) : (lvl != 0);          // R5, R6
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual=%b expected=%b", req, n_cycles, act, exp);
        end
    endtask

    // model of one clock edge, using the inputs present at that edge
    task automatic model_edge();
        bit armed, restart, adv, hit;
        if (rst) begin
            e_txbe = 1'b1; e_txe = 1'b1; e_rxne = 1'b0; e_tmo = 1'b0; m_cnt = 0;   // R1
            return;
        end
        e_txbe = exp_txbe(fifo_mode, int'(tx_level), int'(tx_thresh));
        e_txe  = (tx_level == 0) && !shift_busy;                                  // R4
        e_rxne = exp_rxne(fifo_mode, int'(rx_level), int'(rx_thresh));
        armed   = fifo_mode && (rx_level != 0) && (toc_value != 0);               // R7, R9
        restart = !armed || rx_push || dr_read;                                   // R8, R9
        adv     = tick && (m_cnt < int'(toc_value));                              // R11
        hit     = !restart && adv && (m_cnt + 1 == int'(toc_value));
        if (hit) e_tmo = 1'b1;
        else if (flag_wr && flag_wdata) e_tmo = 1'b0;                             // R10
        if (restart) m_cnt = 0;
        else if (adv) m_cnt = m_cnt + 1;
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        n_cycles++;
        if (!rst) begin
            check(fifo_mode ? "R2" : "R3", tx_buf_empty, e_txbe);
            check("R4", tx_all_empty, e_txe);
            check(fifo_mode ? "R5" : "R6", rx_not_empty, e_rxne);
            check("R7 R8 R9 R10 R11 timeout", timeout_flag, e_tmo);
        end
    endtask

    task automatic quiet();
        tick = 1'b0; rx_push = 1'b0; dr_read = 1'b0; flag_wr = 1'b0; flag_wdata = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        rst = 1'b1; fifo_mode = 1'b1; tx_level = '0; tx_thresh = 4'd2; shift_busy = 1'b0;
        rx_level = '0; rx_thresh = 4'd1; toc_value = 8'd3;
        quiet();
        repeat (3) step();
        // R1: reset values
        check("R1 txbe", tx_buf_empty, 1'b1);
        check("R1 txe", tx_all_empty, 1'b1);
        check("R1 rxne", rx_not_empty, 1'b0);
        check("R1 tmo", timeout_flag, 1'b0);
        rst = 1'b0;
        step();
        check("R1 first cycle tmo", timeout_flag, 1'b0);

        // R2/R4 threshold edges
        tx_level = 4'd2; step(); check("R2 at threshold", tx_buf_empty, 1'b1);
        tx_level = 4'd3; step(); check("R2 above threshold", tx_buf_empty, 1'b0);
        tx_level = 4'd0; shift_busy = 1'b1; step(); check("R4 shifter busy", tx_all_empty, 1'b0);
        shift_busy = 1'b0; step(); check("R4 both empty", tx_all_empty, 1'b1);

        // R7: timeout after three ticks
        rx_level = 4'd2; tick = 1'b1;
        step(); step();
        check("R7 not yet", timeout_flag, 1'b0);
        step();
        check("R7 reached", timeout_flag, 1'b1);
        // R11: saturated, clear stays clear
        step();
        flag_wr = 1'b1; flag_wdata = 1'b0; step(); check("R10 write 0 keeps", timeout_flag, 1'b1);
        flag_wdata = 1'b1; step(); check("R10 write 1 clears", timeout_flag, 1'b0);
        flag_wr = 1'b0; flag_wdata = 1'b0;
        repeat (4) step();
        check("R11 no re-set while saturated", timeout_flag, 1'b0);
        // R8: read restarts, then counts again
        dr_read = 1'b1; step(); dr_read = 1'b0;
        step(); step();
        check("R8 restarted count pending", timeout_flag, 1'b0);
        // R10: set and clear on the same edge, set wins
        flag_wr = 1'b1; flag_wdata = 1'b1; step();
        check("R10 set beats clear", timeout_flag, 1'b1);
        quiet();
        // R9: single-buffer mode holds flag, clears count
        fifo_mode = 1'b0; tick = 1'b1; repeat (3) step();
        check("R9 flag held", timeout_flag, 1'b1);
        rx_level = 4'd1; step(); check("R6 single occupied", rx_not_empty, 1'b1);
        rx_level = 4'd0; step(); check("R6 single empty", rx_not_empty, 1'b0);
        tx_level = 4'd1; step(); check("R3 single full", tx_buf_empty, 1'b0);
        fifo_mode = 1'b1; rx_level = 4'd3; rx_thresh = 4'd3; step();
        check("R5 at threshold", rx_not_empty, 1'b1);
        rx_level = 4'd2; step(); check("R5 below threshold", rx_not_empty, 1'b0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            fifo_mode  = ($urandom_range(0, 9) != 0);
            tx_level   = LVL_W'($urandom_range(0, fifo_mode ? DEPTH : 1));
            tx_thresh  = LVL_W'($urandom_range(0, DEPTH));
            shift_busy = ($urandom_range(0, 2) == 0);
            rx_level   = LVL_W'($urandom_range(0, fifo_mode ? DEPTH : 1));
            rx_thresh  = LVL_W'($urandom_range(0, DEPTH));
            if ($urandom_range(0, 49) == 0) toc_value = TOC_W'($urandom_range(0, 5));
            tick       = ($urandom_range(0, 1) == 1);
            rx_push    = ($urandom_range(0, 15) == 0);
            dr_read    = ($urandom_range(0, 15) == 0);
            flag_wr    = ($urandom_range(0, 7) == 0);
            flag_wdata = ($urandom_range(0, 1) == 1);
            if (rx_level != 0 && $urandom_range(0, 3) != 0) begin
                rx_push = 1'b0; dr_read = 1'b0;
            end
            step();
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule